// File: doc/BRIEF.md
# Time-Aware Gate Control Scheduler

This block opens and closes the transmit gates of eight traffic classes according to a programmable gate control list. Each list entry carries a gate mask, with bit i enabling class i, and an interval in nanoseconds. The schedule is tied to an absolute time taken from a free-running 64-bit nanosecond counter. It repeats with a fixed cycle time, starting from a base time. When the base time is written as zero, the counter value at the moment of enabling becomes the base.

Software loads the list entries and the list length through write strobes. It sets the base time, cycle time and cycle-time extension, and then raises the enable. The block reports the gate vector, the active entry index and a running flag. It also shows the accepted list length, the capability limit for that length, and a flag for a rejected length write. When the enable is low, or before the schedule starts, every gate is open.

Top module: `tas_gate_sched`

## Requirements
- R1: While `sched_en` is low, or after it rises but before the schedule starts, `gate_out` is all ones, `entry_idx` is 0 and `running` is 0.
- R2: When `sched_en` is sampled low, `running` is 0 and all gates are open from the next clock onward, with no further list processing.
- R3: With a nonzero base time not earlier than the counter, the block waits until the counter is at least the base time. It then starts the first entry with a nonzero interval. `gate_out` equals that entry's mask, with bit i for traffic class i.
- R4: Each entry ends at the previous entry's end time plus its own interval. These times are anchored to the schedule, not to the clock at which the end was seen. In the clock where the counter reaches that end time, the next entry becomes active.
- R5: Entries with a zero interval are passed over in the same clock they would become active, so they are never reported in `entry_idx`.
- R6: At each cycle boundary (base + N x cycle time), the list restarts at its first nonzero entry and the current entry is cut short. This does not happen when R7 applies. A boundary takes precedence over an entry ending in the same clock.
- R7: At a boundary, the active entry may be the last nonzero entry and may end after the boundary by no more than the cycle-time extension. If so, that entry runs to its end, and the list then restarts at that end time. The next boundary stays at boundary + cycle time.
- R8: If the list finishes before the cycle boundary, its last entry stays active until that boundary.
- R9: If the nonzero base time is already past when enabling, the start is advanced by one cycle time per clock. The schedule starts at the first boundary that is not earlier than the counter.
- R10: A zero base time captures the counter value in the enabling clock as the base. The schedule starts in the following clock, and entry end times are measured from the captured value.
- R11: A length write above `MAX_LEN` is rejected. On a rejected write, `len_err` goes to 1 and `len_cur` keeps its value. An accepted write loads `len_cur` and clears `len_err`. `len_cap` always reads `MAX_LEN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| time_ns | input | TIME_W (64) | Free-running time counter in nanoseconds |
| sched_en | input | 1 | Scheduler enable |
| base_time | input | TIME_W (64) | Schedule anchor; zero means capture the counter |
| cycle_time | input | IVL_W (32) | Cycle length in ns |
| cycle_ext | input | IVL_W (32) | Cycle-time extension in ns |
| len_wr | input | 1 | List length write strobe |
| len_val | input | LEN_W (4) | List length to write |
| ent_wr | input | 1 | List entry write strobe |
| ent_addr | input | IDX_W (3) | Entry index to write |
| ent_gate | input | NUM_TC (8) | Gate mask of the entry |
| ent_ivl | input | IVL_W (32) | Interval of the entry in ns |
| gate_out | output | NUM_TC (8) | Current gate vector |
| entry_idx | output | IDX_W (3) | Active entry index |
| running | output | 1 | Schedule active |
| len_err | output | 1 | Last length write was rejected |
| len_cur | output | LEN_W (4) | Accepted list length |
| len_cap | output | LEN_W (4) | Maximum list length supported |

## Verification
Some properties are checked by the in-line assertions on every cycle. Disabling ends the schedule by the next clock. The catch-up start search never moves backwards. A held-over entry always has no later nonzero entry behind it. A rejected length write leaves the length unchanged, and the stored length never exceeds the capability. Other behaviour can only be shown by the bench's timed scenarios. This includes the anchoring of entry and cycle boundaries to absolute time, and skipping of zero-interval entries. It also covers the choice between stretching and truncating at a boundary, the catch-up to a past base, and capture of a zero base.

// File: rtl/tas_pkg.sv
package tas_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CATCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RUN   = 2'd3
  } sched_st_e;
endpackage

// File: rtl/tas_gcl_store.sv
module tas_gcl_store #(
  parameter int NUM_TC  = 8,
  parameter int MAX_LEN = 8,
  parameter int IVL_W   = 32,
  parameter int IDX_W   = 3,
  parameter int LEN_W   = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ent_wr,
  input  logic [IDX_W-1:0]                   ent_addr,
  input  logic [NUM_TC-1:0]                  ent_gate,
  input  logic [IVL_W-1:0]                   ent_ivl,
  input  logic                               len_wr,
  input  logic [LEN_W-1:0]                   len_val,
  output logic [MAX_LEN-1:0][NUM_TC-1:0]     gate_q,
  output logic [MAX_LEN-1:0][IVL_W-1:0]      ivl_q,
  output logic [LEN_W-1:0]                   len_q,
  output logic                               len_err_q
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

  // one register slot per entry, each with its own write enable
  for (genvar e = 0; e < MAX_LEN; e++) begin : g_slot
    logic slot_we;
    assign slot_we = ent_wr && (ent_addr == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gate_q[e] <= '0;
        ivl_q[e]  <= '0;
      end else if (slot_we) begin
        gate_q[e] <= ent_gate;
        ivl_q[e]  <= ent_ivl;
      end
    end
  end

  logic             len_ok;
  logic [LEN_W-1:0] len_d;
  logic             err_d;

  always_comb begin
    len_ok = (len_val <= LEN_MAX);
    len_d  = len_q;
    err_d  = len_err_q;
    if (len_wr) begin
      err_d = !len_ok;
      if (len_ok) len_d = len_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q     <= '0;
      len_err_q <= 1'b0;
    end else if (len_wr) begin
      len_q     <= len_d;
      len_err_q <= err_d;
    end
  end

  a_r11_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LEN_MAX);

  a_r11_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (len_wr && (len_val > LEN_MAX)) |=> (len_err_q && $stable(len_q)));
endmodule

// File: rtl/tas_entry_pick.sv
module tas_entry_pick #(
  parameter int MAX_LEN = 8,
  parameter int IVL_W   = 32,
  parameter int IDX_W   = 3,
  parameter int LEN_W   = 4
) (
  input  logic [MAX_LEN-1:0][IVL_W-1:0] ivl,
  input  logic [LEN_W-1:0]              len,
  input  logic [LEN_W-1:0]              from,
  output logic                          found,
  output logic [IDX_W-1:0]              sel
);
  // lowest index >= from, below len, with a nonzero interval
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int j = MAX_LEN - 1; j >= 0; j--) begin
      if ((j >= int'(from)) && (j < int'(len)) && (ivl[j] != '0)) begin
        found = 1'b1;
        sel   = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/tas_sched_ctrl.sv
module tas_sched_ctrl
  import tas_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int TIME_W  = 64,
  parameter int IVL_W   = 32,
  parameter int IDX_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic [TIME_W-1:0]             time_ns,
  input  logic [TIME_W-1:0]             base_time,
  input  logic [IVL_W-1:0]              cycle_time,
  input  logic [IVL_W-1:0]              cycle_ext,
  input  logic [MAX_LEN-1:0][IVL_W-1:0] ivl,
  input  logic                          f0,
  input  logic [IDX_W-1:0]              j0,
  input  logic                          fn,
  input  logic [IDX_W-1:0]              jn,
  output logic [IDX_W-1:0]              idx_q,
  output logic                          running
);
  sched_st_e         st_q, st_d;
  logic [TIME_W-1:0] bnd_q, bnd_d;   // cycle start, then next boundary
  logic [TIME_W-1:0] end_q, end_d;   // end time of the active entry
  logic [IDX_W-1:0]  idx_d;
  logic              hold_q, hold_d; // stretched entry pending restart
  logic              tick_en;

  logic [TIME_W-1:0] ct64, ext64, over, r0_ivl;
  logic [IDX_W-1:0]  r0_idx;
  logic              hit_bnd, hit_end, stretch;

  always_comb begin
    ct64    = TIME_W'(cycle_time);
    ext64   = TIME_W'(cycle_ext);
    hit_bnd = (time_ns >= bnd_q);
    hit_end = (time_ns >= end_q);
    over    = end_q - bnd_q;
    stretch = !fn && (end_q > bnd_q) && (over <= ext64) && !hold_q;
    r0_idx  = f0 ? j0 : '0;
    r0_ivl  = TIME_W'(ivl[r0_idx]);

    st_d   = st_q;
    bnd_d  = bnd_q;
    end_d  = end_q;
    idx_d  = idx_q;
    hold_d = hold_q;

    unique case (st_q)
      ST_IDLE: begin
        if (base_time == '0) begin
          bnd_d = time_ns;
          st_d  = ST_WAIT;
        end else begin
          bnd_d = base_time;
          st_d  = ST_CATCH;
        end
      end
      ST_CATCH: begin
        if ((bnd_q < time_ns) && (ct64 != '0)) bnd_d = bnd_q + ct64;
        else                                    st_d  = ST_WAIT;
      end
      ST_WAIT: begin
        if (hit_bnd) begin
          st_d   = ST_RUN;
          idx_d  = r0_idx;
          end_d  = f0 ? (bnd_q + r0_ivl) : '1;
          bnd_d  = bnd_q + ct64;
          hold_d = 1'b0;
        end
      end
      ST_RUN: begin
        if (hit_bnd) begin
          bnd_d = bnd_q + ct64;
          if (stretch) begin
            hold_d = 1'b1;
          end else begin
            idx_d  = r0_idx;
            end_d  = f0 ? (bnd_q + r0_ivl) : '1;
            hold_d = 1'b0;
          end
        end else if (hit_end) begin
          if (hold_q) begin
            idx_d  = r0_idx;
            end_d  = f0 ? (end_q + r0_ivl) : '1;
            hold_d = 1'b0;
          end else if (fn) begin
            idx_d = jn;
            end_d = end_q + TIME_W'(ivl[jn]);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (!en) begin
      st_d   = ST_IDLE;
      idx_d  = '0;
      hold_d = 1'b0;
    end
  end

  assign tick_en = en || (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bnd_q  <= '0;
      end_q  <= '0;
      idx_q  <= '0;
      hold_q <= 1'b0;
    end else if (tick_en) begin
      st_q   <= st_d;
      bnd_q  <= bnd_d;
      end_q  <= end_d;
      idx_q  <= idx_d;
      hold_q <= hold_d;
    end
  end

  assign running = (st_q == ST_RUN);

  a_r2_stop_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !running);

  a_r9_catch_no_backstep: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CATCH) |=> (bnd_q >= $past(bnd_q)));

  a_r7_hold_only_last: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && running) |-> !fn);
endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched #(
  parameter int NUM_TC  = 8,
  parameter int MAX_LEN = 8,
  parameter int TIME_W  = 64,
  parameter int IVL_W   = 32,
  localparam int IDX_W  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_ns,
  input  logic              sched_en,
  input  logic [TIME_W-1:0] base_time,
  input  logic [IVL_W-1:0]  cycle_time,
  input  logic [IVL_W-1:0]  cycle_ext,
  input  logic              len_wr,
  input  logic [LEN_W-1:0]  len_val,
  input  logic              ent_wr,
  input  logic [IDX_W-1:0]  ent_addr,
  input  logic [NUM_TC-1:0] ent_gate,
  input  logic [IVL_W-1:0]  ent_ivl,
  output logic [NUM_TC-1:0] gate_out,
  output logic [IDX_W-1:0]  entry_idx,
  output logic              running,
  output logic              len_err,
  output logic [LEN_W-1:0]  len_cur,
  output logic [LEN_W-1:0]  len_cap
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [MAX_LEN-1:0][NUM_TC-1:0] gate_q;
  logic [MAX_LEN-1:0][IVL_W-1:0]  ivl_q;
  logic                           f0, fn;
  logic [IDX_W-1:0]               j0, jn, idx_q;
  logic [LEN_W-1:0]               from_next;

  tas_gcl_store #(.NUM_TC(NUM_TC), .MAX_LEN(MAX_LEN), .IVL_W(IVL_W),
                  .IDX_W(IDX_W), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rst_n(rst_int_n),
    .ent_wr(ent_wr), .ent_addr(ent_addr), .ent_gate(ent_gate), .ent_ivl(ent_ivl),
    .len_wr(len_wr), .len_val(len_val),
    .gate_q(gate_q), .ivl_q(ivl_q), .len_q(len_cur), .len_err_q(len_err)
  );

  assign from_next = LEN_W'(idx_q) + LEN_W'(1);

  tas_entry_pick #(.MAX_LEN(MAX_LEN), .IVL_W(IVL_W), .IDX_W(IDX_W),
                   .LEN_W(LEN_W)) u_pick_first (
    .ivl(ivl_q), .len(len_cur), .from('0), .found(f0), .sel(j0)
  );

  tas_entry_pick #(.MAX_LEN(MAX_LEN), .IVL_W(IVL_W), .IDX_W(IDX_W),
                   .LEN_W(LEN_W)) u_pick_next (
    .ivl(ivl_q), .len(len_cur), .from(from_next), .found(fn), .sel(jn)
  );

  tas_sched_ctrl #(.MAX_LEN(MAX_LEN), .TIME_W(TIME_W), .IVL_W(IVL_W),
                   .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .en(sched_en), .time_ns(time_ns),
    .base_time(base_time), .cycle_time(cycle_time), .cycle_ext(cycle_ext),
    .ivl(ivl_q), .f0(f0), .j0(j0), .fn(fn), .jn(jn),
    .idx_q(idx_q), .running(running)
  );

  assign entry_idx = idx_q;
  assign gate_out  = (running && (len_cur != '0)) ? gate_q[idx_q] : '1;
  assign len_cap   = LEN_W'(MAX_LEN);
endmodule

// File: tb/tas_gate_sched_tb.sv
module tas_gate_sched_tb;
  logic        clk;
  logic        rst_n;
  logic [63:0] time_ns, base_time;
  logic        sched_en, len_wr, ent_wr;
  logic [31:0] cycle_time, cycle_ext, ent_ivl;
  logic [3:0]  len_val, len_cur, len_cap;
  logic [2:0]  ent_addr, entry_idx;
  logic [7:0]  ent_gate, gate_out;
  logic        running, len_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  tas_gate_sched u_dut (
    .clk(clk), .rst_n(rst_n), .time_ns(time_ns), .sched_en(sched_en),
    .base_time(base_time), .cycle_time(cycle_time), .cycle_ext(cycle_ext),
    .len_wr(len_wr), .len_val(len_val), .ent_wr(ent_wr), .ent_addr(ent_addr),
    .ent_gate(ent_gate), .ent_ivl(ent_ivl), .gate_out(gate_out),
    .entry_idx(entry_idx), .running(running), .len_err(len_err),
    .len_cur(len_cur), .len_cap(len_cap)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        en;
    logic [31:0] base;
    logic [31:0] ct;
    logic [31:0] ext;
    logic [31:0] tm;
    logic [7:0]  gate;
    logic [2:0]  idx;
    logic        run;
  } vec_t;

  localparam int NV = 48;
  // list: e0 mask 01 ivl 100, e1 mask 02 ivl 0, e2 mask 04 ivl 200, e3 mask 08 ivl 150
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'd1000, 32'd500, 32'd60,  32'd900,  8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd910,  8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd920,  8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd999,  8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd1000, 8'h01, 3'd0, 1'b1},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd1099, 8'h01, 3'd0, 1'b1},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd1100, 8'h04, 3'd2, 1'b1},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd1300, 8'h08, 3'd3, 1'b1},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd1450, 8'h08, 3'd3, 1'b1},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd1499, 8'h08, 3'd3, 1'b1},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd1500, 8'h01, 3'd0, 1'b1},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd1600, 8'h04, 3'd2, 1'b1},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd1800, 8'h08, 3'd3, 1'b1},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd2000, 8'h01, 3'd0, 1'b1},
    '{1'b0, 32'd1000, 32'd500, 32'd60,  32'd2010, 8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd2300, 8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd2300, 8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd2300, 8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd2300, 8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd2300, 8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd2499, 8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd1000, 32'd500, 32'd60,  32'd2500, 8'h01, 3'd0, 1'b1},
    '{1'b0, 32'd1000, 32'd500, 32'd60,  32'd2510, 8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd3000, 32'd420, 32'd60,  32'd2900, 8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd3000, 32'd420, 32'd60,  32'd2900, 8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd3000, 32'd420, 32'd60,  32'd3000, 8'h01, 3'd0, 1'b1},
    '{1'b1, 32'd3000, 32'd420, 32'd60,  32'd3100, 8'h04, 3'd2, 1'b1},
    '{1'b1, 32'd3000, 32'd420, 32'd60,  32'd3300, 8'h08, 3'd3, 1'b1},
    '{1'b1, 32'd3000, 32'd420, 32'd60,  32'd3420, 8'h08, 3'd3, 1'b1},
    '{1'b1, 32'd3000, 32'd420, 32'd60,  32'd3449, 8'h08, 3'd3, 1'b1},
    '{1'b1, 32'd3000, 32'd420, 32'd60,  32'd3450, 8'h01, 3'd0, 1'b1},
    '{1'b1, 32'd3000, 32'd420, 32'd60,  32'd3550, 8'h04, 3'd2, 1'b1},
    '{1'b1, 32'd3000, 32'd420, 32'd60,  32'd3750, 8'h08, 3'd3, 1'b1},
    '{1'b1, 32'd3000, 32'd420, 32'd60,  32'd3840, 8'h08, 3'd3, 1'b1},
    '{1'b1, 32'd3000, 32'd420, 32'd60,  32'd3900, 8'h01, 3'd0, 1'b1},
    '{1'b0, 32'd3000, 32'd420, 32'd60,  32'd4000, 8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd5000, 32'd420, 32'd10,  32'd4900, 8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd5000, 32'd420, 32'd10,  32'd4900, 8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd5000, 32'd420, 32'd10,  32'd5000, 8'h01, 3'd0, 1'b1},
    '{1'b1, 32'd5000, 32'd420, 32'd10,  32'd5100, 8'h04, 3'd2, 1'b1},
    '{1'b1, 32'd5000, 32'd420, 32'd10,  32'd5300, 8'h08, 3'd3, 1'b1},
    '{1'b1, 32'd5000, 32'd420, 32'd10,  32'd5420, 8'h01, 3'd0, 1'b1},
    '{1'b0, 32'd5000, 32'd420, 32'd10,  32'd5430, 8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd0,    32'd500, 32'd0,   32'd6000, 8'hFF, 3'd0, 1'b0},
    '{1'b1, 32'd0,    32'd500, 32'd0,   32'd6008, 8'h01, 3'd0, 1'b1},
    '{1'b1, 32'd0,    32'd500, 32'd0,   32'd6100, 8'h04, 3'd2, 1'b1},
    '{1'b1, 32'd0,    32'd500, 32'd0,   32'd6500, 8'h01, 3'd0, 1'b1},
    '{1'b0, 32'd0,    32'd500, 32'd0,   32'd6510, 8'hFF, 3'd0, 1'b0}
  };

  function automatic string tag_of(int i);
    if (i < 4)   return "R1/R3 wait for base";
    if (i < 6)   return "R3 start at base";
    if (i == 6)  return "R5/R4 skip zero interval";
    if (i == 7)  return "R4 anchored advance";
    if (i < 10)  return "R8 hold last entry";
    if (i == 10) return "R6/R8 restart at boundary";
    if (i < 14)  return "R4/R6 second cycle";
    if (i == 14) return "R2 disable";
    if (i < 22)  return "R9 past base catch-up";
    if (i == 22) return "R2 disable";
    if (i < 28)  return "R3/R4 new base";
    if (i < 35)  return "R7 extension stretch";
    if (i == 35) return "R2 disable";
    if (i < 42)  return "R6 truncation";
    if (i == 42) return "R2 disable";
    if (i < 47)  return "R10 zero base capture";
    return "R2 disable";
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_entry(logic [2:0] a, logic [7:0] g, logic [31:0] v);
    ent_wr = 1'b1; ent_addr = a; ent_gate = g; ent_ivl = v;
    @(negedge clk);
    ent_wr = 1'b0;
  endtask

  task automatic wr_len(logic [3:0] v);
    len_wr = 1'b1; len_val = v;
    @(negedge clk);
    len_wr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; time_ns = '0; base_time = '0; sched_en = 1'b0;
    cycle_time = '0; cycle_ext = '0; len_wr = 1'b0; len_val = '0;
    ent_wr = 1'b0; ent_addr = '0; ent_gate = '0; ent_ivl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk("R1 reset gates", 64'(gate_out), 64'hFF);
    chk("R1 reset index", 64'(entry_idx), 64'd0);
    chk("R1 reset running", 64'(running), 64'd0);
    chk("R11 reset len_err", 64'(len_err), 64'd0);
    chk("R11 capability", 64'(len_cap), 64'd8);

    wr_entry(3'd0, 8'h01, 32'd100);
    wr_entry(3'd1, 8'h02, 32'd0);
    wr_entry(3'd2, 8'h04, 32'd200);
    wr_entry(3'd3, 8'h08, 32'd150);
    wr_len(4'd4);
    chk("R11 length accepted", 64'(len_cur), 64'd4);

    for (int i = 0; i < NV; i++) begin
      sched_en   = VEC[i].en;
      base_time  = {32'b0, VEC[i].base};
      cycle_time = VEC[i].ct;
      cycle_ext  = VEC[i].ext;
      time_ns    = {32'b0, VEC[i].tm};
      @(negedge clk);
      chk(tag_of(i), {52'b0, gate_out, entry_idx, running},
          {52'b0, VEC[i].gate, VEC[i].idx, VEC[i].run});
    end

    // R11: over-capability length rejected, length kept
    wr_len(4'd9);
    chk("R11 reject flag", 64'(len_err), 64'd1);
    chk("R11 reject keeps length", 64'(len_cur), 64'd4);
    wr_len(4'd8);
    chk("R11 accept clears flag", 64'(len_err), 64'd0);
    chk("R11 accept at capability", 64'(len_cur), 64'd8);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule